// File: doc/BRIEF.md
# Hamming-Protected Two-Wire Bus Master

This block is the master side of a two-wire serial link in the I2C style, hardened against bit errors. Every byte on the wire is a 12-bit word: eight data bits followed by four check bits from a shortened cyclic Hamming (12,8) code. Each word is followed by one acknowledge slot. The master drives SCL, frames each transaction with start and stop conditions, and computes the check bits for each word it sends. It decodes every word it receives and repairs single-bit errors.

A host requests a transaction with a one-cycle `start` pulse. The pulse carries a bus index, a 7-bit node address, a read/write flag and, for writes, a data byte. One master serves four independent buses through a 1-of-4 selector. The bus index is captured when the transaction begins. Only that bus sees SCL activity; the other buses are left idle. On completion the block pulses `done` and holds the result until the next transaction: read data, a valid flag, corrected and uncorrectable error flags, and a NACK flag.

Top module: `hc_i2c_master`

## Requirements
- R1: The check nibble of a word is the remainder of data(x)·x^4 divided by x^4+x+1. Bit 11 of the word is the x^11 term. Bits 11..4 carry the data and bits 3..0 carry the check nibble. The word goes out MSB first, and an acknowledge slot follows, so each word takes 13 SCL pulses.
- R2: A transaction begins with SDA falling while SCL is high and ends with SDA rising while SCL is high. At all other times, SDA driven by the master changes only while SCL is low.
- R3: Each bit lasts 4·DIV clock cycles, and SCL is high for the middle 2·DIV of them. The default DIV of 62 gives about 200 kHz from a 50 MHz clock.
- R4: `bus_sel` is captured at `start`. Only the captured bus has SCL toggling or SDA pulled. The other buses keep SCL high and SDA released. A change of `bus_sel` while `busy` is high has no effect.
- R5: A received word whose syndrome equals that of a single bit position is corrected in that bit. `rd_data` then holds the repaired byte, with `err_corrected`=1 and `rd_valid`=1.
- R6: A received word with a non-zero syndrome that matches none of the 12 bit positions sets `err_uncorrectable`=1 and `rd_valid`=0.
- R7: If SDA is high in the acknowledge slot after a word sent by the master, the master goes straight to the stop condition and ends with `nack`=1.
- R8: The first word is {address[6:0], rd}. For a write, the second word is `wr_data`. For a read, the second word comes from the node, and the master drives its acknowledge slot low.
- R9: After reset, `busy`, `done` and all flags are 0, every `scl_o` bit is 1 and every `sda_oe` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; accepted when idle |
| bus_sel | input | 2 | Target bus index |
| slave_addr | input | 7 | Node address |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| wr_data | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| nack | output | 1 | A word sent by the master was not acknowledged |
| rd_data | output | 8 | Decoded read byte |
| rd_valid | output | 1 | `rd_data` is trustworthy |
| err_corrected | output | 1 | The read word had a single-bit error that was repaired |
| err_uncorrectable | output | 1 | The read word could not be repaired |
| scl_o | output | 4 | SCL level for each bus |
| sda_oe | output | 4 | 1 pulls SDA low on that bus |
| sda_i | input | 4 | Sensed SDA level for each bus |

## Verification
The bench drives reads and writes to random buses, addresses and data. Read words come back clean, with one flipped bit, or with two flipped bits. These patterns separate the three decoder outcomes: clean, repaired, and flagged. Some double flips alias onto a single-bit syndrome, so they also show that aliasing is reported as a correction. A directed pair flip whose syndrome is x^12 mod g must give the uncorrectable flag. Directed NACKs on the address word and on the data word check the early stop. A `bus_sel` change in the middle of a transaction checks that the bus binding holds.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int WW = DW + CW;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WORD, ST_STOP} hc_state_e;

  // remainder of a 12-bit polynomial modulo x^4+x+1
  function automatic logic [CW-1:0] hc_mod(input logic [WW-1:0] v);
    logic [WW-1:0] r;
    r = v;
    for (int i = WW-1; i >= CW; i--)
      if (r[i]) r[i -: 5] = r[i -: 5] ^ 5'b10011;
    return r[CW-1:0];
  endfunction

  function automatic logic [CW-1:0] hc_check(input logic [DW-1:0] d);
    return hc_mod({d, {CW{1'b0}}});
  endfunction

  function automatic logic [CW-1:0] hc_pos_syn(input int i);
    return hc_mod(WW'(1) << i);
  endfunction
endpackage

// File: rtl/hc_bitclk.sv
module hc_bitclk #(
  parameter int DIV = 62
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  output logic [1:0] q,
  output logic       q_end
);
  localparam int CNTW = $clog2(DIV + 1);
  logic [CNTW-1:0] cnt;

  assign q_end = en && (cnt == CNTW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= '0;
    end else if (!en) begin
      cnt <= '0;
      q   <= '0;
    end else if (q_end) begin
      cnt <= '0;
      q   <= q + 2'd1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hc_decoder.sv
module hc_decoder
  import hc_pkg::*;
(
  input  logic [WW-1:0] word_i,
  output logic [WW-1:0] fixed_o,
  output logic [WW-1:0] match_o,
  output logic          corrected_o,
  output logic          unc_o
);
  logic [CW-1:0] syn;
  assign syn = hc_mod(word_i);

  for (genvar g = 0; g < WW; g++) begin : g_pos
    assign match_o[g] = (syn != '0) && (syn == hc_pos_syn(g));
  end

  assign fixed_o     = word_i ^ match_o;
  assign corrected_o = |match_o;
  assign unc_o       = (syn != '0) && !(|match_o);
endmodule

// File: rtl/hc_bus_mux.sv
module hc_bus_mux #(
  parameter int NBUS = 4,
  localparam int SW = $clog2(NBUS)
) (
  input  logic [SW-1:0]   sel,
  input  logic            scl_drv,
  input  logic            sda_low,
  input  logic [NBUS-1:0] sda_i,
  output logic [NBUS-1:0] scl_o,
  output logic [NBUS-1:0] sda_oe,
  output logic            sda_sel
);
  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    assign scl_o[b]  = (sel == SW'(b)) ? scl_drv : 1'b1;
    assign sda_oe[b] = (sel == SW'(b)) && sda_low;
  end
  assign sda_sel = sda_i[sel];
endmodule

// File: rtl/hc_i2c_master.sv
module hc_i2c_master
  import hc_pkg::*;
#(
  parameter int NBUS = 4,
  parameter int DIV  = 62,
  localparam int SW  = $clog2(NBUS),
  localparam int AW  = DW - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [SW-1:0]   bus_sel,
  input  logic [AW-1:0]   slave_addr,
  input  logic            rd_nwr,
  input  logic [DW-1:0]   wr_data,
  output logic            busy,
  output logic            done,
  output logic            nack,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic            err_corrected,
  output logic            err_uncorrectable,
  output logic [NBUS-1:0] scl_o,
  output logic [NBUS-1:0] sda_oe,
  input  logic [NBUS-1:0] sda_i
);
  localparam logic [3:0] ACK_IDX = 4'(WW);

  hc_state_e     state;
  logic [1:0]    q;
  logic          q_end, sample_now, word_step;
  logic [3:0]    bit_idx;
  logic          ph, is_read, rd_q, ack_smp;
  logic [DW-1:0] wd_q;
  logic [WW-1:0] tx, rx;
  logic [SW-1:0] sel_q;
  logic          scl_drv, sda_low, sda_sel;
  logic [WW-1:0] dec_fixed, dec_match;
  logic          dec_corr, dec_unc;

  hc_bitclk #(.DIV(DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(state != ST_IDLE), .q(q), .q_end(q_end));

  hc_decoder u_dec (
    .word_i(rx), .fixed_o(dec_fixed), .match_o(dec_match),
    .corrected_o(dec_corr), .unc_o(dec_unc));

  hc_bus_mux #(.NBUS(NBUS)) u_mux (
    .sel(sel_q), .scl_drv(scl_drv), .sda_low(sda_low), .sda_i(sda_i),
    .scl_o(scl_o), .sda_oe(sda_oe), .sda_sel(sda_sel));

  assign busy       = (state != ST_IDLE);
  assign sample_now = q_end && (q == 2'd1);
  assign word_step  = q_end && (q == 2'd3);

  always_comb begin
    scl_drv = 1'b1;
    sda_low = 1'b0;
    case (state)
      ST_START: sda_low = q[1];
      ST_WORD: begin
        scl_drv = (q == 2'd1) || (q == 2'd2);
        sda_low = (bit_idx == ACK_IDX) ? is_read : (!is_read && !tx[4'd11 - bit_idx]);
      end
      ST_STOP: begin
        scl_drv = (q != 2'd0);
        sda_low = (q != 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bit_idx <= '0; ph <= 1'b0; is_read <= 1'b0;
      rd_q <= 1'b0; wd_q <= '0; tx <= '0; rx <= '0; ack_smp <= 1'b0;
      sel_q <= '0; done <= 1'b0; nack <= 1'b0; rd_data <= '0;
      rd_valid <= 1'b0; err_corrected <= 1'b0; err_uncorrectable <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          sel_q <= bus_sel; rd_q <= rd_nwr; wd_q <= wr_data;
          tx <= {slave_addr, rd_nwr, hc_check({slave_addr, rd_nwr})};
          is_read <= 1'b0; ph <= 1'b0; bit_idx <= '0;
          nack <= 1'b0; rd_valid <= 1'b0;
          err_corrected <= 1'b0; err_uncorrectable <= 1'b0;
          state <= ST_START;
        end
        ST_START: if (word_step) begin
          bit_idx <= '0;
          state   <= ST_WORD;
        end
        ST_WORD: begin
          if (sample_now) begin
            if (bit_idx == ACK_IDX) ack_smp <= sda_sel;
            else rx[4'd11 - bit_idx] <= sda_sel;
          end
          if (word_step) begin
            if (bit_idx != ACK_IDX) begin
              bit_idx <= bit_idx + 4'd1;
            end else if (!is_read && ack_smp) begin
              nack  <= 1'b1;
              state <= ST_STOP;
            end else if (!ph) begin
              ph <= 1'b1; bit_idx <= '0; is_read <= rd_q;
              tx <= {wd_q, hc_check(wd_q)};
            end else begin
              if (is_read) begin
                rd_data           <= dec_fixed[WW-1:CW];
                err_corrected     <= dec_corr;
                err_uncorrectable <= dec_unc;
                rd_valid          <= !dec_unc;
              end
              state <= ST_STOP;
            end
          end
        end
        ST_STOP: if (word_step) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: captured bus index holds for the whole transaction
  assert_sel_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sel_q));

  // R4: buses other than the captured one stay idle
  assert_unsel_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((scl_o | (NBUS'(1) << sel_q)) == {NBUS{1'b1}}) && ((sda_oe & ~(NBUS'(1) << sel_q)) == '0));

  // R2: SDA moves under a high SCL only for start or stop
  assert_sda_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drv && $past(scl_drv) && (sda_low != $past(sda_low)))
      |-> (state == ST_START || state == ST_STOP));

  // R5: at most one bit position is chosen for repair
  assert_match_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_match));

  // R5: unless flagged uncorrectable, the repaired word is a codeword
  assert_fix_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_unc |-> (hc_mod(dec_fixed) == '0));
endmodule

// File: tb/hc_i2c_master_tb_top.sv
module hc_i2c_master_tb_top;
  localparam int DIV = 4;
  localparam int NB  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rd_nwr = 1'b0;
  logic [1:0] bus_sel = '0;
  logic [6:0] slave_addr = '0;
  logic [7:0] wr_data = '0;
  logic busy, done, nack, rd_valid, err_corrected, err_uncorrectable;
  logic [7:0] rd_data;
  logic [NB-1:0] scl_o, sda_oe, sda_i, slv_pull;

  assign sda_i = ~(sda_oe | slv_pull);

  always #10 clk = ~clk;

  hc_i2c_master #(.NBUS(NB), .DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_sel(bus_sel),
    .slave_addr(slave_addr), .rd_nwr(rd_nwr), .wr_data(wr_data),
    .busy(busy), .done(done), .nack(nack), .rd_data(rd_data),
    .rd_valid(rd_valid), .err_corrected(err_corrected),
    .err_uncorrectable(err_uncorrectable),
    .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_i));

  int n_checks = 0, n_err = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // serial check-nibble generator, x^4+x+1
  function automatic logic [3:0] b_chk(input logic [7:0] d);
    logic [3:0] r = '0;
    for (int i = 7; i >= 0; i--) begin
      logic fb = d[i] ^ r[3];
      r = {r[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
    end
    return r;
  endfunction

  function automatic bit b_ok(input logic [11:0] w);
    return b_chk(w[11:4]) == w[3:0];
  endfunction

  // returns {unc, corr, data}
  function automatic logic [9:0] b_dec(input logic [11:0] w);
    if (b_ok(w)) return {2'b00, w[11:4]};
    for (int i = 0; i < 12; i++)
      if (b_ok(w ^ (12'd1 << i))) return {2'b01, w[11:4] ^ 8'((12'd1 << i) >> 4)};
    return {2'b10, w[11:4]};
  endfunction

  // bus node model
  int cfg_bus = 0, cfg_nack = 0;
  bit cfg_rd = 0;
  logic [11:0] cfg_rword = '0;
  int fall_cnt = 0, rise_cnt = 0, other_act = 0, period = 0;
  longint cyc = 0, last_rise = 0;
  bit seen_start = 0, seen_stop = 0, ps = 1, pd = 1;
  logic [25:0] cap = '0;

  function automatic bit pull_for(input int k);
    if (k == 12) return cfg_nack != 1;
    if (cfg_rd && k >= 13 && k <= 24) return !cfg_rword[24-k];
    if (!cfg_rd && k == 25) return cfg_nack != 2;
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    bit s, d;
    cyc++;
    s = scl_o[cfg_bus];
    d = sda_i[cfg_bus];
    for (int b = 0; b < NB; b++)
      if (b != cfg_bus && (!scl_o[b] || sda_oe[b])) other_act++;
    if (s && ps && pd && !d) begin
      seen_start = 1; fall_cnt = 0; rise_cnt = 0; slv_pull <= '0;
    end
    if (s && ps && !pd && d) seen_stop = 1;
    if (ps && !s) begin
      slv_pull <= pull_for(fall_cnt) ? (NB'(1) << cfg_bus) : '0;
      fall_cnt++;
    end
    if (!ps && s) begin
      if (rise_cnt < 26) cap[25-rise_cnt] = d;
      if (rise_cnt == 1) period = int'(cyc - last_rise);
      last_rise = cyc;
      rise_cnt++;
    end
    ps = s; pd = d;
  end

  task automatic run(input int bus, input logic [6:0] a, input bit rd, input logic [7:0] wd,
                     input logic [7:0] rbyte, input logic [11:0] flip, input int nk, input bit move_sel);
    logic [11:0] w0, w1;
    logic [9:0] exp;
    bit got;
    @(negedge clk);
    cfg_bus = bus; cfg_nack = nk; cfg_rd = rd;
    cfg_rword = {rbyte, b_chk(rbyte)} ^ flip;
    seen_start = 0; seen_stop = 0; other_act = 0; period = 0; cap = '0;
    bus_sel = 2'(bus); slave_addr = a; rd_nwr = rd; wr_data = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    for (int i = 0; i < 4000 && !got; i++) begin
      @(negedge clk);
      if (move_sel && i == 60) bus_sel = 2'(bus + 1);
      if (done) got = 1;
    end
    check(got, "R7 done within limit", 32'(got), 1);
    w0 = {a, rd, b_chk({a, rd})};
    check(cap[25:14] == w0, "R1 R8 address word", 32'(cap[25:14]), 32'(w0));
    check(seen_start && seen_stop, "R2 start and stop seen", {seen_start, seen_stop}, 2'b11);
    check(period == 4*DIV, "R3 bit period", period, 4*DIV);
    check(other_act == 0, "R4 other buses idle", other_act, 0);
    check(nack == (nk != 0), "R7 nack flag", nack, 32'(nk != 0));
    if (nk == 1) check(rise_cnt == 14, "R7 stop after address", rise_cnt, 14);
    else if (!rd) begin
      w1 = {wd, b_chk(wd)};
      check(cap[12:1] == w1, "R1 R8 write word", 32'(cap[12:1]), 32'(w1));
      check(rise_cnt == 27, "R1 pulse count", rise_cnt, 27);
    end else begin
      exp = b_dec(cfg_rword);
      check(cap[0] == 1'b0, "R8 master ack on read", cap[0], 0);
      check(err_uncorrectable == exp[9], "R6 uncorrectable flag", err_uncorrectable, exp[9]);
      check(rd_valid == !exp[9], "R6 valid flag", rd_valid, !exp[9]);
      check(err_corrected == exp[8], "R5 corrected flag", err_corrected, exp[8]);
      if (!exp[9]) check(rd_data == exp[7:0], "R5 read data", rd_data, exp[7:0]);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!busy && !done && !nack && !rd_valid && !err_corrected && !err_uncorrectable,
          "R9 reset flags", {busy, done, nack, rd_valid}, 0);
    check(scl_o == 4'hF && sda_oe == 4'h0, "R9 reset bus", {scl_o, sda_oe}, 8'hF0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(scl_o == 4'hF && sda_oe == 4'h0 && !busy, "R9 idle after reset", {scl_o, sda_oe}, 8'hF0);
    // directed corners
    run(0, 7'h2A, 0, 8'hA5, 8'h00, 12'h000, 0, 0);
    run(1, 7'h11, 1, 8'h00, 8'h3C, 12'h000, 0, 0);
    run(2, 7'h05, 1, 8'h00, 8'hC3, 12'h010, 0, 0);
    run(3, 7'h7F, 1, 8'h00, 8'h5A, 12'h801, 0, 0);
    run(0, 7'h40, 1, 8'h00, 8'hFF, 12'h008, 0, 0);
    run(1, 7'h33, 0, 8'h0F, 8'h00, 12'h000, 1, 0);
    run(2, 7'h34, 0, 8'hF0, 8'h00, 12'h000, 2, 0);
    run(3, 7'h01, 0, 8'h81, 8'h00, 12'h000, 0, 1);
    run(1, 7'h02, 1, 8'h00, 8'h99, 12'h000, 0, 1);
    // random mix
    for (int t = 0; t < 24; t++) begin
      int ne, p1, p2;
      logic [11:0] fm;
      ne = int'($urandom % 3);
      p1 = int'($urandom % 12);
      p2 = (p1 + 1 + int'($urandom % 11)) % 12;
      fm = '0;
      if (ne >= 1) fm[p1] = 1'b1;
      if (ne == 2) fm[p2] = 1'b1;
      run(int'($urandom % 4), 7'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), fm, 0, 0);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule